// File: doc/BRIEF.md
# Semaphore Access Error Capture Unit

This unit sits beside a hardware semaphore array and judges every acquire or release operation that a master presents. The caller supplies the operation (kind, master, semaphore number) together with the current state of the addressed semaphore: whether it is free, which master holds it, and which masters already have a request waiting in its queue. The unit answers in the same cycle whether the operation may proceed; an illegal operation is blocked so the lock logic leaves the semaphore and its queue untouched.

Illegal operations are sorted into four coded violations. The first violation is latched, with the offending master and semaphore number, into a read-only error word that software reads on the memory-mapped bus, and the erring master's own error interrupt line pulses. That line then stays silent until the end-of-interrupt decoder broadcasts its error re-arm. A write to the error-clear address returns the error word to the no-error state so that the next violation can be captured.

Top module: `sem_err_unit`

## Requirements
- R1: After reset the error word reads zero and no error interrupt line is active; every master's line is armed.
- R2: A release of a semaphore that is free is blocked and records code 3'b001.
- R3: A release of a held semaphore by a master other than its holder is blocked and records code 3'b010.
- R4: An acquire by the master that already holds the semaphore is blocked and records code 3'b011, also when that master has a request queued (code 3'b011 wins over 3'b100).
- R5: An acquire by a master whose bit in the pending-request vector is set (bit i belongs to master i) is blocked and records code 3'b100.
- R6: A legal operation (acquire by a master not holding and not queued, release by the holder) is allowed and does not change the error word.
- R7: A read at offset 0x500 returns the error word with the master id in bits 15:8, the semaphore number in bits 7:3, the code in bits 2:0 and zero in bits 31:16; a read at any other offset, or with no read strobe, returns zero.
- R8: While the error word holds a nonzero code, further violations are still blocked but neither change the word nor pulse any interrupt line.
- R9: A write at offset 0x504 clears the error word in the next cycle; a violation in the same cycle as that write is captured instead of being lost.
- R10: A captured violation pulses bit m of the interrupt vector (m = offending master) for exactly one cycle, one clock after the operation, and only if line m is armed; firing disarms line m.
- R11: The re-arm broadcast arms every line; a violation captured in the same cycle as the re-arm fires its line, which then ends disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_release | input | 1 | 1 = release, 0 = acquire |
| op_master | input | MID_W | Master issuing the operation |
| op_sem | input | SEM_W | Semaphore number addressed |
| st_free | input | 1 | Addressed semaphore is free |
| st_owner | input | MID_W | Current holder of the addressed semaphore |
| st_pend | input | NUM_MASTERS | Masters with a queued request on the addressed semaphore |
| op_allow | output | 1 | Operation may change semaphore state |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_rdata | output | 32 | Bus read data |
| eoi_err_rearm | input | 1 | Broadcast re-arm of all error lines |
| err_irq | output | NUM_MASTERS | Per-master error interrupt pulses |

## Verification
Two pairs of functions can coincide in one cycle: an error-clear write with a new violation, and the re-arm broadcast with a violation on a disarmed line. Directed cases place each pair in the same cycle and check that the new violation is latched and that the line fires and ends disarmed; seeded random stimulus then issues clears, re-arms and operations on independent draws so both pairings recur many times, each judged against a bench model of the error word and the arm state.

// File: rtl/sem_err_pkg.sv
package sem_err_pkg;

    localparam int FID_W  = 8;
    localparam int SNUM_W = 5;
    localparam logic [11:0] ERR_OFS = 12'h500;
    localparam logic [11:0] CLR_OFS = 12'h504;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'b000,
        ERR_REL_FREE  = 3'b001,
        ERR_REL_OTHER = 3'b010,
        ERR_ACQ_OWNED = 3'b011,
        ERR_ACQ_QUEUE = 3'b100
    } err_code_e;

    typedef struct packed {
        logic [FID_W-1:0]  fid;
        logic [SNUM_W-1:0] snum;
        err_code_e         code;
    } err_rec_t;

    // Ownership violation outranks the queued-request violation.
    function automatic err_code_e classify(input logic release_op,
                                           input logic is_free,
                                           input logic owner_hit,
                                           input logic pend_hit);
        err_code_e c;
        c = ERR_NONE;
        if (release_op) begin
            if (is_free)         c = ERR_REL_FREE;
            else if (!owner_hit) c = ERR_REL_OTHER;
        end else begin
            if (!is_free && owner_hit) c = ERR_ACQ_OWNED;
            else if (pend_hit)         c = ERR_ACQ_QUEUE;
        end
        return c;
    endfunction

endpackage

// File: rtl/sem_err_classify.sv
module sem_err_classify
    import sem_err_pkg::*;
#(
    parameter int NUM_MASTERS = 3,
    parameter int MID_W       = 2
) (
    input  logic                   op_valid,
    input  logic                   op_release,
    input  logic [MID_W-1:0]       op_master,
    input  logic                   st_free,
    input  logic [MID_W-1:0]       st_owner,
    input  logic [NUM_MASTERS-1:0] st_pend,
    output err_code_e              code,
    output logic                   is_err,
    output logic                   op_allow
);

    logic pend_self;

    always_comb begin
        pend_self = 1'b0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (op_master == MID_W'(i)) pend_self = st_pend[i];
        end
    end

    always_comb begin
        code     = classify(op_release, st_free, st_owner == op_master, pend_self);
        is_err   = op_valid && (code != ERR_NONE);
        op_allow = op_valid && (code == ERR_NONE);
    end

endmodule

// File: rtl/sem_err_capture.sv
module sem_err_capture
    import sem_err_pkg::*;
#(
    parameter int MID_W = 2,
    parameter int SEM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_err,
    input  err_code_e        code,
    input  logic [MID_W-1:0] op_master,
    input  logic [SEM_W-1:0] op_sem,
    input  logic             clr,
    output err_rec_t         err_q,
    output logic             capture
);

    // A clear in the same cycle frees the slot for the new violation.
    assign capture = is_err && (clr || err_q.code == ERR_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (capture) begin
            err_q.fid  <= FID_W'(op_master);
            err_q.snum <= SNUM_W'(op_sem);
            err_q.code <= code;
        end else if (clr) begin
            err_q <= '0;
        end
    end

endmodule

// File: rtl/sem_err_irq.sv
module sem_err_irq #(
    parameter int NUM_MASTERS = 3,
    parameter int MID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic [MID_W-1:0]       op_master,
    input  logic                   rearm,
    output logic [NUM_MASTERS-1:0] err_irq
);

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_line
        logic armed_q;
        logic fire;

        assign fire = capture && (op_master == MID_W'(g)) && (armed_q || rearm);

        always_ff @(posedge clk) begin
            if (rst) begin
                armed_q    <= 1'b1;
                err_irq[g] <= 1'b0;
            end else begin
                armed_q    <= (armed_q || rearm) && !fire;
                err_irq[g] <= fire;
            end
        end
    end

endmodule

// File: rtl/sem_err_unit.sv
module sem_err_unit
    import sem_err_pkg::*;
#(
    parameter int NUM_MASTERS = 3,
    parameter int NUM_SEM     = 32,
    localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
    localparam int SEM_W      = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic                   op_release,
    input  logic [MID_W-1:0]       op_master,
    input  logic [SEM_W-1:0]       op_sem,
    input  logic                   st_free,
    input  logic [MID_W-1:0]       st_owner,
    input  logic [NUM_MASTERS-1:0] st_pend,
    output logic                   op_allow,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [11:0]            bus_addr,
    output logic [31:0]            bus_rdata,
    input  logic                   eoi_err_rearm,
    output logic [NUM_MASTERS-1:0] err_irq
);

    err_code_e code;
    logic      is_err;
    logic      capture;
    logic      clr;
    err_rec_t  err_q;

    assign clr = bus_wr && (bus_addr == CLR_OFS);

    sem_err_classify #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_cls (
        .op_valid  (op_valid),
        .op_release(op_release),
        .op_master (op_master),
        .st_free   (st_free),
        .st_owner  (st_owner),
        .st_pend   (st_pend),
        .code      (code),
        .is_err    (is_err),
        .op_allow  (op_allow)
    );

    sem_err_capture #(.MID_W(MID_W), .SEM_W(SEM_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .is_err   (is_err),
        .code     (code),
        .op_master(op_master),
        .op_sem   (op_sem),
        .clr      (clr),
        .err_q    (err_q),
        .capture  (capture)
    );

    sem_err_irq #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .op_master(op_master),
        .rearm    (eoi_err_rearm),
        .err_irq  (err_irq)
    );

    assign bus_rdata = (bus_rd && bus_addr == ERR_OFS) ? {16'h0000, err_q} : 32'h0;

endmodule

// File: rtl/sem_err_unit_chk.sv
module sem_err_unit_chk #(
    parameter int NUM_MASTERS = 3,
    parameter int MID_W       = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   op_valid,
    input logic                   op_release,
    input logic [MID_W-1:0]       op_master,
    input logic                   st_free,
    input logic [MID_W-1:0]       st_owner,
    input logic                   op_allow,
    input logic                   bus_wr,
    input logic [11:0]            bus_addr,
    input logic [NUM_MASTERS-1:0] err_irq,
    input logic [15:0]            err_word
);

    logic clr_seen;
    assign clr_seen = bus_wr && (bus_addr == 12'h504);

    AST_REL_FREE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_release && st_free) |-> !op_allow); // R2

    AST_REL_OTHER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_release && !st_free && st_owner != op_master) |-> !op_allow); // R3

    AST_FIRST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        (err_word[2:0] != 3'b000 && !clr_seen) |=> $stable(err_word)); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr_seen && !(op_valid && !op_allow)) |=> err_word == 16'h0000); // R9

    AST_IRQ_SINGLE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_irq)); // R10

    AST_IRQ_HAS_RECORD: assert property (@(posedge clk) disable iff (rst)
        (|err_irq) |-> err_word[2:0] != 3'b000); // R10

    AST_IRQ_AFTER_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_allow && err_word[2:0] == 3'b000) |=> err_word[2:0] != 3'b000); // R8

endmodule

bind sem_err_unit sem_err_unit_chk #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_release(op_release),
    .op_master (op_master),
    .st_free   (st_free),
    .st_owner  (st_owner),
    .op_allow  (op_allow),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .err_irq   (err_irq),
    .err_word  (err_q)
);

// File: tb/sem_err_unit_tb.sv
`timescale 1ns/1ps
module sem_err_unit_tb;

    localparam int NM = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_release;
    logic [1:0]  op_master, st_owner;
    logic [4:0]  op_sem;
    logic        st_free;
    logic [2:0]  st_pend;
    logic        op_allow;
    logic        bus_rd, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_rdata;
    logic        eoi_err_rearm;
    logic [2:0]  err_irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_reg;
    logic [2:0]  m_armed;
    logic [2:0]  m_irq;

    always #2.5 clk = ~clk;

    sem_err_unit #(.NUM_MASTERS(NM), .NUM_SEM(32)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_release(op_release),
        .op_master(op_master), .op_sem(op_sem), .st_free(st_free),
        .st_owner(st_owner), .st_pend(st_pend), .op_allow(op_allow),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .eoi_err_rearm(eoi_err_rearm), .err_irq(err_irq)
    );

    function automatic logic [2:0] exp_code(logic rel, logic fr, logic [1:0] own,
                                            logic [1:0] m, logic [2:0] pend);
        if (rel) begin
            if (fr) return 3'b001;
            if (own != m) return 3'b010;
            return 3'b000;
        end
        if (!fr && own == m) return 3'b011;
        if (pend[m]) return 3'b100;
        return 3'b000;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // One operation cycle: drive at negedge, check allow, then model the edge.
    task automatic step(string tag, logic v, logic rel, logic [1:0] m, logic [4:0] s,
                        logic fr, logic [1:0] own, logic [2:0] pend,
                        logic clr, logic rearm, logic [11:0] raddr);
        logic [2:0]  c;
        logic        err, fire;
        logic [15:0] base;
        @(negedge clk);
        op_valid = v; op_release = rel; op_master = m; op_sem = s;
        st_free = fr; st_owner = own; st_pend = pend;
        bus_wr = clr; bus_addr = clr ? 12'h504 : raddr; eoi_err_rearm = rearm;
        #1;
        c   = exp_code(rel, fr, own, m, pend);
        err = v && (c != 3'b000);
        if (v) check({tag, " allow"}, {31'b0, op_allow}, {31'b0, !err});
        @(posedge clk);
        base = clr ? 16'h0 : m_reg;
        fire = 1'b0;
        if (err && base[2:0] == 3'b000) begin
            m_reg = {6'b0, m, s, c};
            fire  = m_armed[m] || rearm;
        end else begin
            m_reg = base;
        end
        m_armed = m_armed | {3{rearm}};
        m_irq = 3'b000;
        if (fire) begin
            m_armed[m] = 1'b0;
            m_irq[m]   = 1'b1;
        end
        #1;
        op_valid = 1'b0; bus_wr = 1'b0; eoi_err_rearm = 1'b0; bus_addr = raddr;
        #0.5;
        check({tag, " irq"}, {29'b0, err_irq}, {29'b0, m_irq});
        check({tag, " word"}, bus_rdata,
              (bus_rd && raddr == 12'h500) ? {16'b0, m_reg} : 32'h0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; op_valid = 0; op_release = 0; op_master = 0; op_sem = 0;
        st_free = 1; st_owner = 0; st_pend = 0; bus_rd = 1; bus_wr = 0;
        bus_addr = 12'h500; eoi_err_rearm = 0;
        m_reg = 0; m_armed = 3'b111; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 word", bus_rdata, 32'h0);
        check("R1 irq", {29'b0, err_irq}, 32'h0);

        // R6 legal acquire and release
        step("R6 acq", 1, 0, 2'd0, 5'd4, 1, 2'd0, 3'b000, 0, 0, 12'h500);
        step("R6 rel", 1, 1, 2'd0, 5'd4, 0, 2'd0, 3'b000, 0, 0, 12'h500);
        // R2 release of free semaphore
        step("R2", 1, 1, 2'd1, 5'd5, 1, 2'd0, 3'b000, 0, 0, 12'h500);
        // R8 second violation ignored
        step("R8", 1, 1, 2'd2, 5'd6, 1, 2'd0, 3'b000, 0, 0, 12'h500);
        // R9 clear
        step("R9 clr", 0, 0, 2'd0, 5'd0, 1, 2'd0, 3'b000, 1, 0, 12'h500);
        // R10 disarmed line captures but stays quiet
        step("R10", 1, 1, 2'd1, 5'd7, 1, 2'd0, 3'b000, 0, 0, 12'h500);
        // R3 release by non-holder (clear in same cycle, R9)
        step("R3", 1, 1, 2'd0, 5'd31, 0, 2'd2, 3'b000, 1, 0, 12'h500);
        // R4 acquire own with pending set
        step("R4", 1, 0, 2'd2, 5'd7, 0, 2'd2, 3'b100, 1, 0, 12'h500);
        // R5 acquire with queued request
        step("R5", 1, 0, 2'd0, 5'd9, 0, 2'd1, 3'b001, 1, 0, 12'h500);
        // R11 re-arm in same cycle as violation on disarmed line 1
        step("R11", 1, 0, 2'd1, 5'd3, 0, 2'd1, 3'b000, 1, 1, 12'h500);
        step("R11 after", 1, 0, 2'd1, 5'd3, 0, 2'd1, 3'b000, 1, 0, 12'h500);
        // R7 other offsets and no strobe
        step("R7 clr addr", 0, 0, 2'd0, 5'd0, 1, 2'd0, 3'b000, 0, 0, 12'h504);
        step("R7 zero addr", 0, 0, 2'd0, 5'd0, 1, 2'd0, 3'b000, 0, 0, 12'h000);
        bus_rd = 1'b0;
        step("R7 no rd", 0, 0, 2'd0, 5'd0, 1, 2'd0, 3'b000, 0, 0, 12'h500);
        bus_rd = 1'b1;

        for (int i = 0; i < 600; i++) begin
            step("R8 rnd", 1'($urandom_range(0, 3) != 0), 1'($urandom),
                 2'($urandom_range(0, 2)), 5'($urandom), 1'($urandom),
                 2'($urandom_range(0, 2)), 3'($urandom),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0), 12'h500);
        end
        finish_run();
    end

endmodule